// File: doc/BRIEF.md
# Linked Descriptor Chain Walker

This block runs one DMA channel over a chain of descriptor lists held in word-addressed memory. The host points it at the first list and issues a start command. The block reads the list's two header words: a link to the next list, and a word that holds a status half and a frame-size half. It then reads the fragment entries one pair at a time. Each pair is a count word and an address word, and for each pair the block hands one fragment request to a downstream data mover.

When a frame's fragments are all handed over, the block writes the list's status back with the completion flag set. It then posts an end-of-frame event. If the link word is zero it also marks the status as end of channel, posts an end-of-channel event and goes idle. Otherwise it follows the link to the next list.

Faulty lists raise an adapter-check event. A stop command halts the walk at once. Events wait in a one-deep slot until the host acknowledges them.

Top module: `dlf_fetch`

## Requirements
- R1: After reset, mem_req, frag_valid and irq_valid are all low.
- R2: A command with bit 31 (start) set, accepted while idle, makes the block issue a read of word cmd_addr (the link word) on the very next cycle.
- R3: List layout is word 0 = link, word 1 = {frame size [31:16], status [15:0]}, entry i count at word 2+2i and address at word 3+2i. Each fragment is presented as frag_addr = address word and frag_len = count[15:0], in entry order. It is held stable until frag_ready is high.
- R4: Bit 31 of a count word marks the last entry of the list. Without that bit, the walk stops after the tenth entry (MAX_FRAGS).
- R5: When the channel is started as receive (cmd_rx=1) with cfg_one_frag=1, only the first entry of each list is used. For a transmit channel cfg_one_frag has no effect.
- R6: After the last fragment, word 1 is rewritten with status | 0x4000, and also | 0x0800 when the link word is zero. The frame size is kept. This write lands before the end-of-frame event is visible.
- R7: A nonzero link makes the block continue with the list at that address. A zero link ends the chain, after which the block is idle until the next start.
- R8: Event codes on irq_type are: 1 transmit end-of-frame, 3 receive end-of-frame, 5 transmit end-of-channel, 7 receive end-of-channel, 6 adapter check.
- R9: A list whose status bits 13:12 are not both set raises event 6, emits no fragment and is not written back. A zero count[15:0] on a non-last entry raises event 6 after the earlier entries were emitted, again with no writeback.
- R10: An event stays on irq_valid/irq_type until irq_ack. irq_valid drops the cycle after the acknowledge. Only one event is pending at a time, and the walk waits while the slot is full.
- R11: A command with bit 30 (stop) set returns the block to idle at once. From the next cycle on there is no frag_valid, no memory request and no new event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command word strobe |
| cmd_word | input | 32 | Command: bit 31 start, bit 30 stop |
| cmd_addr | input | AW | First list word address, taken with start |
| cmd_rx | input | 1 | Channel kind taken with start: 1 receive, 0 transmit |
| cfg_one_frag | input | 1 | Single-entry list mode, taken with start |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Read data valid (one cycle after a read request) |
| mem_rdata | input | 32 | Read data |
| frag_valid | output | 1 | Fragment request valid |
| frag_ready | input | 1 | Data mover takes the fragment |
| frag_addr | output | 32 | Fragment buffer address |
| frag_len | output | 16 | Fragment byte count |
| irq_valid | output | 1 | Event pending |
| irq_type | output | 3 | Event code |
| irq_ack | input | 1 | Host acknowledges the pending event |

## Verification
A start is due as a link-word read on the cycle after the start is sampled. A stop takes effect on the cycle after the stop is sampled, and an acknowledged event is gone on the cycle after the acknowledge. The bench checks these three on the falling edge exactly one cycle after the stimulus edge. Fragments are counted on each falling edge where valid and ready are both high, and address and length are checked against their running index. The memory model writes on the same edge on which the write is issued, so the rewritten status word is read back at the moment the end-of-frame event is first seen.

// File: rtl/dlf_pkg.sv
package dlf_pkg;
    localparam int CMD_GO_BIT   = 31;
    localparam int CMD_STOP_BIT = 30;

    localparam logic [15:0] ST_READY = 16'h3000;
    localparam logic [15:0] ST_DONE  = 16'h4000;
    localparam logic [15:0] ST_EOC   = 16'h0800;

    localparam logic [2:0] EV_TX_EOF = 3'd1;
    localparam logic [2:0] EV_RX_EOF = 3'd3;
    localparam logic [2:0] EV_TX_EOC = 3'd5;
    localparam logic [2:0] EV_CHECK  = 3'd6;
    localparam logic [2:0] EV_RX_EOC = 3'd7;

    typedef enum logic [3:0] {
        W_IDLE, W_HDR0, W_HDR1, W_CNT, W_ADR, W_EMIT, W_WBACK, W_EOF, W_EOC, W_FAULT
    } walk_st_e;

    typedef enum logic [1:0] {F_LINK, F_STAT, F_CNT, F_ADR} field_e;
endpackage

// File: rtl/dlf_addr_gen.sv
module dlf_addr_gen
    import dlf_pkg::*;
#(
    parameter int AW    = 16,
    parameter int IDX_W = 4
) (
    input  logic [AW-1:0]    base,
    input  field_e           field,
    input  logic [IDX_W-1:0] idx,
    output logic [AW-1:0]    addr
);
    logic [AW-1:0] pair_off;

    always_comb begin
        pair_off = AW'(2) + (AW'(idx) << 1);
        case (field)
            F_LINK:  addr = base;
            F_STAT:  addr = base + AW'(1);
            F_CNT:   addr = base + pair_off;
            F_ADR:   addr = base + pair_off + AW'(1);
            default: addr = base;
        endcase
    end
endmodule

// File: rtl/dlf_irq_slot.sv
module dlf_irq_slot (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       post,
    input  logic [2:0] post_type,
    input  logic       ack,
    output logic       busy,
    output logic       irq_valid,
    output logic [2:0] irq_type
);
    typedef struct packed {
        logic       valid;
        logic [2:0] typ;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (slot_q.valid && ack) slot_d.valid = 1'b0;
        if (post) begin
            slot_d.valid = 1'b1;
            slot_d.typ   = post_type;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign busy      = slot_q.valid;
    assign irq_valid = slot_q.valid;
    assign irq_type  = slot_q.typ;

    p_single_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
        post |-> !slot_q.valid);
    p_hold_until_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q.valid && !ack) |=> (irq_valid && $stable(irq_type)));
    p_ack_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q.valid && ack) |=> !irq_valid);
    p_event_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        post |-> (post_type == 3'd1 || post_type == 3'd3 || post_type == 3'd5 ||
                  post_type == 3'd6 || post_type == 3'd7));
endmodule

// File: rtl/dlf_walker.sv
module dlf_walker
    import dlf_pkg::*;
#(
    parameter int AW        = 16,
    parameter int MAX_FRAGS = 10,
    parameter int IDX_W     = $clog2(MAX_FRAGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [31:0]      cmd_word,
    input  logic [AW-1:0]    cmd_addr,
    input  logic             cmd_rx,
    input  logic             cfg_one_frag,
    output logic             mem_req,
    output logic             mem_we,
    output field_e           field,
    output logic [IDX_W-1:0] idx,
    output logic [AW-1:0]    base,
    input  logic [AW-1:0]    mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic             mem_rvalid,
    input  logic [31:0]      mem_rdata,
    output logic             frag_valid,
    input  logic             frag_ready,
    output logic [31:0]      frag_addr,
    output logic [15:0]      frag_len,
    input  logic             irq_busy,
    output logic             post,
    output logic [2:0]       post_type
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(MAX_FRAGS - 1);

    typedef struct packed {
        walk_st_e         st;
        logic             pend;
        logic [AW-1:0]    base;
        logic [31:0]      link;
        logic [15:0]      stat;
        logic [15:0]      fsize;
        logic [IDX_W-1:0] idx;
        logic [15:0]      len;
        logic             last;
        logic [31:0]      fadr;
        logic             rx;
        logic             one;
    } walk_t;

    walk_t w_d, w_q;

    logic go, stop, one_eff, slot_end, eff_last, unused_cmd;

    assign go         = cmd_valid && cmd_word[CMD_GO_BIT];
    assign stop       = cmd_valid && cmd_word[CMD_STOP_BIT];
    assign one_eff    = w_q.rx && w_q.one;
    assign slot_end   = (w_q.idx == LAST_IDX);
    assign eff_last   = mem_rdata[31] || one_eff || slot_end;
    assign unused_cmd = ^cmd_word[29:0];

    always_comb begin
        w_d       = w_q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_wdata = '0;
        field     = F_LINK;
        post      = 1'b0;
        post_type = EV_CHECK;
        case (w_q.st)
            W_IDLE: begin
                if (go) begin
                    w_d.base = cmd_addr;
                    w_d.rx   = cmd_rx;
                    w_d.one  = cfg_one_frag;
                    w_d.pend = 1'b0;
                    w_d.st   = W_HDR0;
                end
            end
            W_HDR0: begin
                field = F_LINK;
                if (!w_q.pend) begin
                    mem_req  = 1'b1;
                    w_d.pend = 1'b1;
                end else if (mem_rvalid) begin
                    w_d.pend = 1'b0;
                    w_d.link = mem_rdata;
                    w_d.st   = W_HDR1;
                end
            end
            W_HDR1: begin
                field = F_STAT;
                if (!w_q.pend) begin
                    mem_req  = 1'b1;
                    w_d.pend = 1'b1;
                end else if (mem_rvalid) begin
                    w_d.pend  = 1'b0;
                    w_d.stat  = mem_rdata[15:0];
                    w_d.fsize = mem_rdata[31:16];
                    w_d.idx   = '0;
                    w_d.st    = ((mem_rdata[15:0] & ST_READY) == ST_READY) ? W_CNT : W_FAULT;
                end
            end
            W_CNT: begin
                field = F_CNT;
                if (!w_q.pend) begin
                    mem_req  = 1'b1;
                    w_d.pend = 1'b1;
                end else if (mem_rvalid) begin
                    w_d.pend = 1'b0;
                    w_d.len  = mem_rdata[15:0];
                    w_d.last = eff_last;
                    w_d.st   = (mem_rdata[15:0] == 16'h0 && !eff_last) ? W_FAULT : W_ADR;
                end
            end
            W_ADR: begin
                field = F_ADR;
                if (!w_q.pend) begin
                    mem_req  = 1'b1;
                    w_d.pend = 1'b1;
                end else if (mem_rvalid) begin
                    w_d.pend = 1'b0;
                    w_d.fadr = mem_rdata;
                    w_d.st   = W_EMIT;
                end
            end
            W_EMIT: begin
                if (frag_ready) begin
                    if (w_q.last) begin
                        w_d.st = W_WBACK;
                    end else begin
                        w_d.idx = w_q.idx + IDX_W'(1);
                        w_d.st  = W_CNT;
                    end
                end
            end
            W_WBACK: begin
                field     = F_STAT;
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = {w_q.fsize, w_q.stat | ST_DONE | ((w_q.link == 32'h0) ? ST_EOC : 16'h0)};
                w_d.st    = W_EOF;
            end
            W_EOF: begin
                if (!irq_busy) begin
                    post      = 1'b1;
                    post_type = w_q.rx ? EV_RX_EOF : EV_TX_EOF;
                    if (w_q.link == 32'h0) begin
                        w_d.st = W_EOC;
                    end else begin
                        w_d.base = w_q.link[AW-1:0];
                        w_d.st   = W_HDR0;
                    end
                end
            end
            W_EOC: begin
                if (!irq_busy) begin
                    post      = 1'b1;
                    post_type = w_q.rx ? EV_RX_EOC : EV_TX_EOC;
                    w_d.st    = W_IDLE;
                end
            end
            W_FAULT: begin
                if (!irq_busy) begin
                    post      = 1'b1;
                    post_type = EV_CHECK;
                    w_d.st    = W_IDLE;
                end
            end
            default: w_d.st = W_IDLE;
        endcase
        if (stop) begin
            w_d.st   = W_IDLE;
            w_d.pend = 1'b0;
            mem_req  = 1'b0;
            mem_we   = 1'b0;
            post     = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign idx        = w_q.idx;
    assign base       = w_q.base;
    assign frag_valid = (w_q.st == W_EMIT);
    assign frag_addr  = w_q.fadr;
    assign frag_len   = w_q.len;

    p_go_reads_link_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (w_q.st == W_IDLE && go && !stop) |=> (mem_req && !mem_we && mem_addr == $past(cmd_addr)));
    p_frag_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (frag_valid && !frag_ready && !stop) |=> (frag_valid && $stable(frag_addr) && $stable(frag_len)));
    p_wback_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_wdata[14] && mem_wdata[13:12] == 2'b11));
    p_stop_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (!frag_valid && !mem_req && !post));
    p_idx_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frag_valid |-> (w_q.idx <= LAST_IDX));
endmodule

// File: rtl/dlf_fetch.sv
module dlf_fetch
    import dlf_pkg::*;
#(
    parameter int AW        = 16,
    parameter int MAX_FRAGS = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [31:0]   cmd_word,
    input  logic [AW-1:0] cmd_addr,
    input  logic          cmd_rx,
    input  logic          cfg_one_frag,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic          mem_rvalid,
    input  logic [31:0]   mem_rdata,
    output logic          frag_valid,
    input  logic          frag_ready,
    output logic [31:0]   frag_addr,
    output logic [15:0]   frag_len,
    output logic          irq_valid,
    output logic [2:0]    irq_type,
    input  logic          irq_ack
);
    localparam int IDX_W = $clog2(MAX_FRAGS);

    field_e           field;
    logic [IDX_W-1:0] idx;
    logic [AW-1:0]    base;
    logic             irq_busy, post;
    logic [2:0]       post_type;

    dlf_walker #(.AW(AW), .MAX_FRAGS(MAX_FRAGS), .IDX_W(IDX_W)) walker_i (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_word(cmd_word), .cmd_addr(cmd_addr),
        .cmd_rx(cmd_rx), .cfg_one_frag(cfg_one_frag),
        .mem_req(mem_req), .mem_we(mem_we), .field(field), .idx(idx), .base(base),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .frag_valid(frag_valid), .frag_ready(frag_ready),
        .frag_addr(frag_addr), .frag_len(frag_len),
        .irq_busy(irq_busy), .post(post), .post_type(post_type)
    );

    dlf_addr_gen #(.AW(AW), .IDX_W(IDX_W)) addr_i (
        .base(base), .field(field), .idx(idx), .addr(mem_addr)
    );

    dlf_irq_slot slot_i (
        .clk(clk), .rst_n(rst_n), .post(post), .post_type(post_type), .ack(irq_ack),
        .busy(irq_busy), .irq_valid(irq_valid), .irq_type(irq_type)
    );
endmodule

// File: tb/dlf_fetch_tb_top.sv
module dlf_fetch_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam logic [31:0] GO   = 32'h8000_0000;
    localparam logic [31:0] STOP = 32'h4000_0000;

    // vector: [15] rx, [14] one_frag, [13:10] last entry (15 = none),
    //         [9:6] expected fragments, [5:3] end-of-frame code, [2:0] end-of-channel code
    localparam logic [15:0] VEC [6] = '{
        {1'b0, 1'b0, 4'd2,  4'd3,  3'd1, 3'd5},
        {1'b1, 1'b0, 4'd0,  4'd1,  3'd3, 3'd7},
        {1'b1, 1'b1, 4'd15, 4'd1,  3'd3, 3'd7},
        {1'b0, 1'b1, 4'd4,  4'd5,  3'd1, 3'd5},
        {1'b0, 1'b0, 4'd15, 4'd10, 3'd1, 3'd5},
        {1'b1, 1'b0, 4'd9,  4'd10, 3'd3, 3'd7}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [31:0] cmd_word = '0;
    logic [AW-1:0] cmd_addr = '0;
    logic cmd_rx = 1'b0, cfg_one_frag = 1'b0;
    logic mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata;
    logic mem_rvalid;
    logic [31:0] mem_rdata;
    logic frag_valid, frag_ready;
    logic [31:0] frag_addr;
    logic [15:0] frag_len;
    logic irq_valid;
    logic [2:0] irq_type;
    logic irq_ack = 1'b0;

    logic [31:0] mem [0:255];
    logic tb_we = 1'b0;
    logic [7:0] tb_a = '0;
    logic [31:0] tb_d = '0;
    int rdy_mode = 0;
    int cyc = 0;
    int n_chk = 0, n_fail = 0, frag_seen = 0;
    logic [2:0] ev_log [4];
    int ev_n = 0;
    bit fin = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dlf_fetch #(.AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .cmd_addr(cmd_addr), .cmd_rx(cmd_rx), .cfg_one_frag(cfg_one_frag),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .frag_valid(frag_valid), .frag_ready(frag_ready),
        .frag_addr(frag_addr), .frag_len(frag_len),
        .irq_valid(irq_valid), .irq_type(irq_type), .irq_ack(irq_ack)
    );

    assign frag_ready = (rdy_mode == 0) || (rdy_mode == 1 && cyc[1]);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (tb_we) mem[tb_a] <= tb_d;
        if (mem_req && mem_we) mem[mem_addr[7:0]] <= mem_wdata;
        mem_rvalid <= rst_n && mem_req && !mem_we;
        mem_rdata  <= mem[mem_addr[7:0]];
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && frag_valid && frag_ready) begin
            chk(frag_addr == 32'hA000 + 32'(frag_seen), "R3 fragment address", frag_addr, 32'hA000 + 32'(frag_seen));
            chk(frag_len == 16'(frag_seen + 1), "R3 fragment length", 32'(frag_len), 32'(frag_seen + 1));
            frag_seen++;
        end
    end

    always @(posedge clk) begin
        if (cyc > 150000 && !fin) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic wr_word(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        tb_we = 1'b1; tb_a = a; tb_d = d;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic build_list(input logic [7:0] b, input logic [31:0] link, input logic [15:0] stat,
                              input int nlast, input int start, input int zero_at);
        wr_word(b, link);
        wr_word(b + 8'd1, {16'h0100 + 16'(b), stat});
        for (int i = 0; i < 10; i++) begin
            logic [31:0] c;
            c = 32'(start + i + 1);
            if (i == nlast) c[31] = 1'b1;
            if (i == zero_at) c = 32'h0;
            wr_word(b + 8'(2 + 2 * i), c);
            wr_word(b + 8'(3 + 2 * i), 32'hA000 + 32'(start + i));
        end
    endtask

    task automatic start_go(input logic [7:0] b, input logic rx, input logic one);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_word = GO; cmd_addr = AW'(b); cmd_rx = rx; cfg_one_frag = one;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_word = '0;
    endtask

    task automatic collect_events();
        bit done;
        done = 0;
        for (int g = 0; g < 4000 && !done; g++) begin
            @(negedge clk);
            if (irq_valid) begin
                if (ev_n < 4) ev_log[ev_n] = irq_type;
                ev_n++;
                if (irq_type == 3'd5 || irq_type == 3'd6 || irq_type == 3'd7) done = 1;
                irq_ack = 1'b1;
                @(negedge clk);
                irq_ack = 1'b0;
                chk(!irq_valid, "R10 clear after ack", 32'(irq_valid), 32'h0);
            end
        end
        if (!done) chk(0, "R7 chain end reached", 32'h0, 32'h1);
    endtask

    task automatic run_chain(input logic [7:0] b, input logic rx, input logic one);
        frag_seen = 0;
        ev_n = 0;
        start_go(b, rx, one);
        chk(mem_req && !mem_we && mem_addr == AW'(b), "R2 link read after start", 32'(mem_addr), 32'(b));
        collect_events();
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        // R1: outputs quiet during and right after reset
        chk(!mem_req, "R1 mem_req", 32'(mem_req), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!frag_valid, "R1 frag_valid", 32'(frag_valid), 32'h0);
        chk(!irq_valid, "R1 irq_valid", 32'(irq_valid), 32'h0);

        // table walk: single-list chains (R3 R4 R5 R6 R8)
        for (int v = 0; v < 6; v++) begin
            logic [15:0] t;
            t = VEC[v];
            rdy_mode = v % 2;
            build_list(8'h20, 32'h0, 16'h3000, int'(t[13:10]), 0, 15);
            run_chain(8'h20, t[15], t[14]);
            chk(frag_seen == int'(t[9:6]), (t[15] && t[14]) ? "R5 one-entry count" : "R4 fragment count",
                32'(frag_seen), 32'(t[9:6]));
            chk(ev_n == 2 && ev_log[0] == t[5:3] && ev_log[1] == t[2:0], "R8 event codes",
                {ev_log[0], ev_log[1], 24'(ev_n)}, {t[5:3], t[2:0], 24'd2});
            chk(mem[8'h21] == 32'h0120_7800, "R6 status writeback", mem[8'h21], 32'h0120_7800);
        end
        rdy_mode = 0;

        // R7: two-list chain
        build_list(8'h20, 32'h60, 16'h3000, 1, 0, 15);
        build_list(8'h60, 32'h0, 16'h3000, 2, 2, 15);
        run_chain(8'h20, 1'b0, 1'b0);
        chk(frag_seen == 5, "R7 fragments over chain", 32'(frag_seen), 32'd5);
        chk(ev_n == 3 && ev_log[0] == 3'd1 && ev_log[1] == 3'd1 && ev_log[2] == 3'd5, "R7 events over chain",
            32'(ev_n), 32'd3);
        chk(mem[8'h21] == 32'h0120_7000, "R6 mid-chain status", mem[8'h21], 32'h0120_7000);
        chk(mem[8'h61] == 32'h0160_7800, "R6 chain-end status", mem[8'h61], 32'h0160_7800);

        // R9: list not marked ready
        build_list(8'h90, 32'h0, 16'h2000, 0, 0, 15);
        run_chain(8'h90, 1'b0, 1'b0);
        chk(frag_seen == 0, "R9 no fragment on unready list", 32'(frag_seen), 32'h0);
        chk(ev_n == 1 && ev_log[0] == 3'd6, "R9 adapter check", 32'(ev_log[0]), 32'd6);
        chk(mem[8'h91] == 32'h0190_2000, "R9 no writeback", mem[8'h91], 32'h0190_2000);

        // R9: zero count on a non-last entry
        build_list(8'h90, 32'h0, 16'h3000, 3, 0, 1);
        run_chain(8'h90, 1'b1, 1'b0);
        chk(frag_seen == 1, "R9 entries before zero count", 32'(frag_seen), 32'h1);
        chk(ev_n == 1 && ev_log[0] == 3'd6, "R9 zero count check", 32'(ev_log[0]), 32'd6);
        chk(mem[8'h91] == 32'h0190_3000, "R9 zero count no writeback", mem[8'h91], 32'h0190_3000);

        // R10: event held while unacknowledged, walk waits
        begin
            int bad;
            build_list(8'h20, 32'h0, 16'h3000, 0, 0, 15);
            frag_seen = 0;
            ev_n = 0;
            start_go(8'h20, 1'b0, 1'b0);
            for (int g = 0; g < 200 && !irq_valid; g++) @(negedge clk);
            bad = 0;
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                if (!irq_valid || irq_type != 3'd1 || mem_req) bad++;
            end
            chk(bad == 0, "R10 event held without ack", 32'(bad), 32'h0);
            collect_events();
            chk(ev_n == 2 && ev_log[1] == 3'd5, "R10 next event after ack", 32'(ev_log[1]), 32'd5);
        end

        // R11: stop while a fragment waits
        begin
            int act;
            rdy_mode = 2;
            build_list(8'h20, 32'h0, 16'h3000, 2, 0, 15);
            frag_seen = 0;
            start_go(8'h20, 1'b0, 1'b0);
            for (int g = 0; g < 200 && !frag_valid; g++) @(negedge clk);
            cmd_valid = 1'b1; cmd_word = STOP;
            @(negedge clk);
            cmd_valid = 1'b0; cmd_word = '0;
            chk(!frag_valid && !mem_req, "R11 quiet after stop", {31'h0, frag_valid | mem_req}, 32'h0);
            act = 0;
            for (int k = 0; k < 10; k++) begin
                @(negedge clk);
                if (frag_valid || mem_req || irq_valid) act++;
            end
            chk(act == 0, "R11 stays idle", 32'(act), 32'h0);
            rdy_mode = 0;
            run_chain(8'h20, 1'b0, 1'b0);
            chk(frag_seen == 3 && ev_n == 2, "R11 restart after stop", 32'(frag_seen), 32'd3);
        end

        fin = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule